// File: doc/BRIEF.md
# Address Table Placement Search Engine

This block is a sequencer that decides where a new forwarding-table entry should go. It accepts one request: a 48-bit MAC address, a 12-bit VLAN ID, a lookup mode (address or VLAN) and a tagging flag. It then reads every table slot once, one slot per clock, through a synchronous read port. From that single pass it reports one of four outcomes: the index of an existing matching entry, the index of the lowest free slot, the index of the lowest slot that may be evicted, or no place at all.

Each table entry is 64 bits wide. The fields are:

- bits 63:62: unicast ageing class
- bits 61:60: entry type (0 free, 1 address, 2 VLAN, 3 VLAN-plus-address)
- bits 59:48: VLAN ID
- bits 47:0: MAC address. Octet i (i = 0..5) occupies bits [47-8i : 40-8i], so bit 40 is the group (multicast) bit.

The table itself lives outside the block, and so does the write that follows the search. Software or a higher-level controller issues the request, waits for `done`, and then writes the entry at the reported index.

Top module: `ase_place_engine`

## Requirements
- R1: After reset, `busy` and `done` are low, `not_found` is low, `result_kind` is 0 (none), `result_idx` is 0 and `tbl_rd_en` is low.
- R2: In address mode (`cmd_vlan_mode`=0), an entry is a hit only if all of the following hold:
  - its type (bits 61:60) is 1 or 3;
  - its VLAN ID (bits 59:48) equals the request VLAN ID;
  - all 48 MAC bits equal the request MAC, with octet i stored at bits [47-8i : 40-8i].
  
  Type 0 and type 2 entries never hit in this mode.
- R3: In address mode with `cmd_tagged`=0, the block compares against VLAN ID 0, whatever is on `cmd_vid`.
- R4: In VLAN mode (`cmd_vlan_mode`=1), an entry is a hit only if its type is 2 and its VLAN ID equals `cmd_vid`. The MAC bits and `cmd_tagged` are ignored.
- R5: The result follows a fixed priority: a hit (`result_kind`=1) first, then a free entry of type 0 (`result_kind`=2), then an evictable entry (`result_kind`=3). In each tier the lowest index wins.
- R6: An entry is evictable only if all of the following hold:
  - its type is 1 or 3;
  - bit 40 is 0;
  - its class in bits 63:62 is 1 or 3. Class 0 (persistent) and class 2 (vendor-prefix) entries are never evicted.
- R7: When no slot qualifies for any tier, `done` comes with `not_found`=1, `result_kind`=0 and `result_idx`=0.
- R8: `busy` rises in the cycle after a request is accepted and falls in the same cycle that `done` rises. `cmd_valid` is ignored while `busy` is high, and the result then belongs to the first request.
- R9: A request is accepted on a clock edge where `cmd_valid` is high and `busy` is low.
  - The read port then issues indices 0 to ENTRIES-1 on consecutive cycles. The table returns data one cycle after each read.
  - `done` is a one-cycle pulse that is high in the cycle after the (ENTRIES+1)th edge following acceptance. The result stays valid until the next request completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request strobe |
| cmd_vlan_mode | input | 1 | 0 address lookup, 1 VLAN lookup |
| cmd_tagged | input | 1 | Address mode: use `cmd_vid` (1) or VLAN 0 (0) |
| cmd_mac | input | 48 | Requested MAC, octet 0 in bits 47:40 |
| cmd_vid | input | 12 | Requested VLAN ID |
| busy | output | 1 | Search in progress |
| tbl_rd_en | output | 1 | Table read request |
| tbl_rd_idx | output | IDX_W | Table read index |
| tbl_rd_data | input | 64 | Entry returned one cycle after the read |
| done | output | 1 | One-cycle completion pulse |
| not_found | output | 1 | No placement exists (valid with `done`) |
| result_kind | output | 2 | 0 none, 1 hit, 2 free, 3 evictable |
| result_idx | output | IDX_W | Chosen table index |

## Verification
The bench counts edges from the acceptance edge. It samples 1 ns after each edge. It expects `busy` high and `done` low through edge ENTRIES, and expects `done`, `busy` low and the result after edge ENTRIES+1. One edge later, `done` must be low again.

Expected outcomes come from a reference walk over the bench's own table copy, computed before the request is issued. The table is then left untouched until `done`. Requests injected while the engine is busy are checked through the final result, which must still answer the first request.

// File: rtl/ase_pkg.sv
package ase_pkg;
  localparam int ENTRY_W   = 64;
  localparam int MAC_W     = 48;
  localparam int VID_W     = 12;
  localparam int VID_LSB   = 48;
  localparam int TYPE_LSB  = 60;
  localparam int CLASS_LSB = 62;
  localparam int GROUP_BIT = 40;
  localparam int OCTETS    = MAC_W / 8;

  localparam logic [1:0] ETYPE_FREE  = 2'd0;
  localparam logic [1:0] ETYPE_ADDR  = 2'd1;
  localparam logic [1:0] ETYPE_VLAN  = 2'd2;
  localparam logic [1:0] ETYPE_VADDR = 2'd3;

  localparam logic [1:0] UCLS_PERSIST = 2'd0;
  localparam logic [1:0] UCLS_PREFIX  = 2'd2;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_HIT   = 2'd1,
    KIND_FREE  = 2'd2,
    KIND_EVICT = 2'd3
  } place_kind_e;

  typedef struct packed {
    logic             vlan_mode;
    logic [MAC_W-1:0] mac;
    logic [VID_W-1:0] vid;
  } look_req_t;
endpackage

// File: rtl/ase_entry_classify.sv
module ase_entry_classify
  import ase_pkg::*;
(
  input  logic [ENTRY_W-1:0] entry,
  input  look_req_t          req,
  output logic               is_hit,
  output logic               is_free,
  output logic               is_evict
);
  logic [1:0]        etype;
  logic [1:0]        ucls;
  logic [VID_W-1:0]  evid;
  logic [OCTETS-1:0] oct_eq;
  logic              is_addr;

  assign etype = entry[TYPE_LSB +: 2];
  assign ucls  = entry[CLASS_LSB +: 2];
  assign evid  = entry[VID_LSB +: VID_W];

  for (genvar g = 0; g < OCTETS; g++) begin : g_oct
    assign oct_eq[g] = (entry[MAC_W-1-8*g -: 8] == req.mac[MAC_W-1-8*g -: 8]);
  end

  always_comb begin
    is_addr  = (etype == ETYPE_ADDR) || (etype == ETYPE_VADDR);
    is_free  = (etype == ETYPE_FREE);
    is_evict = is_addr && !entry[GROUP_BIT] &&
               (ucls != UCLS_PERSIST) && (ucls != UCLS_PREFIX);
    if (req.vlan_mode) begin
      is_hit = (etype == ETYPE_VLAN) && (evid == req.vid);
    end else begin
      is_hit = is_addr && (evid == req.vid) && (&oct_eq);
    end
  end
endmodule

// File: rtl/ase_scan_ctrl.sv
module ase_scan_ctrl #(
  parameter  int ENTRIES = 16,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_idx,
  output logic             eval_vld,
  output logic [IDX_W-1:0] eval_idx,
  output logic             eval_last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic             issuing_q, issuing_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             last_issue;
  logic             eval_vld_q, eval_last_q;
  logic [IDX_W-1:0] eval_idx_q;

  assign last_issue = (cnt_q == LAST_IDX);
  assign rd_en      = issuing_q;
  assign rd_idx     = cnt_q;

  always_comb begin
    issuing_d = issuing_q;
    cnt_d     = cnt_q;
    if (start) begin
      issuing_d = 1'b1;
      cnt_d     = '0;
    end else if (issuing_q) begin
      if (last_issue) begin
        issuing_d = 1'b0;
        cnt_d     = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issuing_q   <= 1'b0;
      cnt_q       <= '0;
      eval_vld_q  <= 1'b0;
      eval_last_q <= 1'b0;
      eval_idx_q  <= '0;
    end else begin
      issuing_q   <= issuing_d;
      cnt_q       <= cnt_d;
      eval_vld_q  <= rd_en;
      eval_last_q <= rd_en && last_issue;
      if (rd_en) eval_idx_q <= rd_idx;
    end
  end

  assign eval_vld  = eval_vld_q;
  assign eval_idx  = eval_idx_q;
  assign eval_last = eval_last_q;

  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (rd_idx == IDX_W'($past(rd_idx) + 1'b1))); // R9
  AST_EVAL_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en) |-> (eval_vld && eval_idx == $past(rd_idx))); // R9
endmodule

// File: rtl/ase_tier_select.sv
module ase_tier_select
  import ase_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             eval_vld,
  input  logic [IDX_W-1:0] eval_idx,
  input  logic             eval_last,
  input  logic             is_hit,
  input  logic             is_free,
  input  logic             is_evict,
  output logic             done,
  output place_kind_e      kind,
  output logic [IDX_W-1:0] idx
);
  logic             hit_v_q, hit_v_d, free_v_q, free_v_d, ev_v_q, ev_v_d;
  logic [IDX_W-1:0] hit_i_q, hit_i_d, free_i_q, free_i_d, ev_i_q, ev_i_d;
  logic             done_q, done_d;
  place_kind_e      kind_q, kind_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    hit_v_d = hit_v_q;   hit_i_d  = hit_i_q;
    free_v_d = free_v_q; free_i_d = free_i_q;
    ev_v_d = ev_v_q;     ev_i_d   = ev_i_q;
    if (start) begin
      hit_v_d = 1'b0; free_v_d = 1'b0; ev_v_d = 1'b0;
    end else if (eval_vld) begin
      if (is_hit && !hit_v_q)     begin hit_v_d  = 1'b1; hit_i_d  = eval_idx; end
      if (is_free && !free_v_q)   begin free_v_d = 1'b1; free_i_d = eval_idx; end
      if (is_evict && !ev_v_q)    begin ev_v_d   = 1'b1; ev_i_d   = eval_idx; end
    end
    done_d = eval_vld && eval_last;
    if (hit_v_d)       begin kind_d = KIND_HIT;   idx_d = hit_i_d;  end
    else if (free_v_d) begin kind_d = KIND_FREE;  idx_d = free_i_d; end
    else if (ev_v_d)   begin kind_d = KIND_EVICT; idx_d = ev_i_d;   end
    else               begin kind_d = KIND_NONE;  idx_d = '0;       end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_v_q <= 1'b0; free_v_q <= 1'b0; ev_v_q <= 1'b0;
      hit_i_q <= '0;   free_i_q <= '0;   ev_i_q <= '0;
      done_q  <= 1'b0;
      kind_q  <= KIND_NONE;
      idx_q   <= '0;
    end else begin
      hit_v_q <= hit_v_d; free_v_q <= free_v_d; ev_v_q <= ev_v_d;
      hit_i_q <= hit_i_d; free_i_q <= free_i_d; ev_i_q <= ev_i_d;
      done_q  <= done_d;
      if (done_d) begin
        kind_q <= kind_d;
        idx_q  <= idx_d;
      end
    end
  end

  assign done = done_q;
  assign kind = kind_q;
  assign idx  = idx_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_HIT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_v_q && !start) |=> (hit_v_q && $stable(hit_i_q))); // R5
endmodule

// File: rtl/ase_place_engine.sv
module ase_place_engine
  import ase_pkg::*;
#(
  parameter  int ENTRIES = 16,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic               cmd_vlan_mode,
  input  logic               cmd_tagged,
  input  logic [47:0]        cmd_mac,
  input  logic [11:0]        cmd_vid,
  output logic               busy,
  output logic               tbl_rd_en,
  output logic [IDX_W-1:0]   tbl_rd_idx,
  input  logic [63:0]        tbl_rd_data,
  output logic               done,
  output logic               not_found,
  output logic [1:0]         result_kind,
  output logic [IDX_W-1:0]   result_idx
);
  logic             busy_q, busy_d;
  logic             start;
  look_req_t        req_q, req_d;
  logic             eval_vld, eval_last;
  logic [IDX_W-1:0] eval_idx;
  logic             is_hit, is_free, is_evict;
  place_kind_e      kind;

  assign start = cmd_valid && !busy_q;

  always_comb begin
    req_d.vlan_mode = cmd_vlan_mode;
    req_d.mac       = cmd_mac;
    req_d.vid       = (cmd_vlan_mode || cmd_tagged) ? cmd_vid : '0;
    busy_d = busy_q;
    if (start)                      busy_d = 1'b1;
    else if (eval_vld && eval_last) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      req_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (start) req_q <= req_d;
    end
  end

  ase_scan_ctrl #(.ENTRIES(ENTRIES)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rd_en(tbl_rd_en), .rd_idx(tbl_rd_idx),
    .eval_vld(eval_vld), .eval_idx(eval_idx), .eval_last(eval_last)
  );

  ase_entry_classify u_class (
    .entry(tbl_rd_data), .req(req_q),
    .is_hit(is_hit), .is_free(is_free), .is_evict(is_evict)
  );

  ase_tier_select #(.IDX_W(IDX_W)) u_tier (
    .clk(clk), .rst_n(rst_n), .start(start),
    .eval_vld(eval_vld), .eval_idx(eval_idx), .eval_last(eval_last),
    .is_hit(is_hit), .is_free(is_free), .is_evict(is_evict),
    .done(done), .kind(kind), .idx(result_idx)
  );

  assign busy        = busy_q;
  assign result_kind = kind;
  assign not_found   = done && (kind == KIND_NONE);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(req_q)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_RD_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd_en |-> busy); // R9
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (32'(result_idx) < ENTRIES)); // R5
endmodule

// File: tb/test_ase_place_engine.sv
`timescale 1ns/1ps
module test_ase_place_engine;
  localparam int N = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_vlan_mode, cmd_tagged;
  logic [47:0] cmd_mac;
  logic [11:0] cmd_vid;
  logic busy, tbl_rd_en, done, not_found;
  logic [IW-1:0] tbl_rd_idx, result_idx;
  logic [63:0] tbl_rd_data;
  logic [1:0] result_kind;
  logic [63:0] mem [N];

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  always @(posedge clk) if (tbl_rd_en) tbl_rd_data <= mem[tbl_rd_idx];

  ase_place_engine #(.ENTRIES(N)) i_ase_place_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_vlan_mode(cmd_vlan_mode),
    .cmd_tagged(cmd_tagged), .cmd_mac(cmd_mac), .cmd_vid(cmd_vid), .busy(busy),
    .tbl_rd_en(tbl_rd_en), .tbl_rd_idx(tbl_rd_idx), .tbl_rd_data(tbl_rd_data),
    .done(done), .not_found(not_found), .result_kind(result_kind), .result_idx(result_idx)
  );

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [1:0] cls, input logic [1:0] ty,
                                     input logic [11:0] vid, input logic [47:0] mac);
    return {cls, ty, vid, mac};
  endfunction

  function automatic void model(input logic vm, input logic tg, input logic [47:0] mac,
                                input logic [11:0] vid, output logic [1:0] kind, output logic [IW-1:0] idx);
    logic [11:0] ev = (vm || tg) ? vid : 12'd0;
    int h = -1, f = -1, e = -1;
    for (int i = 0; i < N; i++) begin
      logic [1:0] ty = mem[i][61:60];
      logic [1:0] cl = mem[i][63:62];
      logic addr = (ty == 2'd1) || (ty == 2'd3);
      logic hit = vm ? (ty == 2'd2 && mem[i][59:48] == ev)
                     : (addr && mem[i][59:48] == ev && mem[i][47:0] == mac);
      if (hit && h < 0) h = i;
      if (ty == 2'd0 && f < 0) f = i;
      if (addr && !mem[i][40] && (cl == 2'd1 || cl == 2'd3) && e < 0) e = i;
    end
    if (h >= 0)      begin kind = 2'd1; idx = IW'(h); end
    else if (f >= 0) begin kind = 2'd2; idx = IW'(f); end
    else if (e >= 0) begin kind = 2'd3; idx = IW'(e); end
    else             begin kind = 2'd0; idx = '0; end
  endfunction

  task automatic run(input string tag, input logic vm, input logic tg, input logic [47:0] mac,
                     input logic [11:0] vid, input bit inject);
    logic [1:0] ek;
    logic [IW-1:0] ei;
    model(vm, tg, mac, vid, ek, ei);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_vlan_mode = vm; cmd_tagged = tg; cmd_mac = mac; cmd_vid = vid;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (inject) begin
      repeat (2) @(negedge clk);
      cmd_valid = 1'b1; cmd_vlan_mode = ~vm; cmd_tagged = 1'b1; cmd_mac = ~mac; cmd_vid = vid + 12'd1;
      repeat (3) @(negedge clk);
      cmd_valid = 1'b0;
    end
    while (!(tbl_rd_en && tbl_rd_idx == IW'(N-1))) @(negedge clk);
    @(posedge clk); #1;
    check("R9", "done early", {63'd0, done}, 64'd0);
    check("R8", "busy before done", {63'd0, busy}, 64'd1);
    @(posedge clk); #1;
    check("R9", "done due", {63'd0, done}, 64'd1);
    check("R8", "busy at done", {63'd0, busy}, 64'd0);
    check(tag, "kind", {62'd0, result_kind}, {62'd0, ek});
    check(tag, "index", {60'd0, result_idx}, {60'd0, ei});
    check(ek == 2'd0 ? "R7" : tag, "not_found", {63'd0, not_found}, {63'd0, ek == 2'd0});
    @(posedge clk); #1;
    check("R9", "done pulse", {63'd0, done}, 64'd0);
  endtask

  localparam logic [47:0] MA = 48'h00_11_22_33_44_55;
  localparam logic [47:0] MB = 48'h00_11_22_33_44_54;
  localparam logic [47:0] MC = 48'h80_11_22_33_44_55;
  localparam logic [47:0] MG = 48'h01_00_5E_00_00_01;

  function automatic logic [47:0] pick_mac(input int s);
    case (s % 4)
      0: return MA;
      1: return MB;
      2: return MC;
      default: return MG;
    endcase
  endfunction

  task automatic fill_persist();
    for (int i = 0; i < N; i++) mem[i] = mk(2'd0, 2'd1, 12'd7, MB);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_vlan_mode = 1'b0; cmd_tagged = 1'b0;
    cmd_mac = '0; cmd_vid = '0;
    for (int i = 0; i < N; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "busy", {63'd0, busy}, 64'd0);
    check("R1", "done", {63'd0, done}, 64'd0);
    check("R1", "not_found", {63'd0, not_found}, 64'd0);
    check("R1", "kind", {62'd0, result_kind}, 64'd0);
    check("R1", "index", {60'd0, result_idx}, 64'd0);
    check("R1", "rd_en", {63'd0, tbl_rd_en}, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // R2: address hit at 7; wrong vid at 2, VLAN type at 1, other-octet MACs elsewhere
    fill_persist();
    mem[1] = mk(2'd0, 2'd2, 12'd5, MA);
    mem[2] = mk(2'd0, 2'd1, 12'd6, MA);
    mem[4] = mk(2'd0, 2'd3, 12'd5, MC);
    mem[7] = mk(2'd0, 2'd3, 12'd5, MA);
    run("R2", 1'b0, 1'b1, MA, 12'd5, 1'b0);
    check("R2", "hit index 7", {60'd0, result_idx}, 64'd7);

    // R3: untagged uses VLAN 0
    fill_persist();
    mem[3] = mk(2'd0, 2'd1, 12'd5, MA);
    mem[9] = mk(2'd0, 2'd1, 12'd0, MA);
    run("R3", 1'b0, 1'b0, MA, 12'd5, 1'b0);
    check("R3", "untagged hit 9", {60'd0, result_idx}, 64'd9);

    // R4: VLAN mode ignores MAC; address entry with same vid not a hit
    fill_persist();
    mem[3] = mk(2'd0, 2'd1, 12'd5, MA);
    mem[9] = mk(2'd1, 2'd2, 12'd5, MG);
    run("R4", 1'b1, 1'b0, MA, 12'd5, 1'b0);
    check("R4", "vlan hit 9", {60'd0, result_idx}, 64'd9);

    // R5: priority hit > free > evict
    fill_persist();
    mem[1]  = mk(2'd1, 2'd1, 12'd7, MB);
    mem[10] = mk(2'd0, 2'd0, 12'd0, 48'd0);
    mem[13] = mk(2'd0, 2'd0, 12'd0, 48'd0);
    mem[12] = mk(2'd0, 2'd1, 12'd3, MA);
    run("R5", 1'b0, 1'b1, MA, 12'd3, 1'b0);
    check("R5", "hit wins", {62'd0, result_kind}, 64'd1);
    mem[12] = mk(2'd0, 2'd1, 12'd3, MC);
    run("R5", 1'b0, 1'b1, MA, 12'd3, 1'b0);
    check("R5", "lowest free 10", {60'd0, result_idx}, 64'd10);

    // R6: eviction filter
    fill_persist();
    mem[2] = mk(2'd2, 2'd1, 12'd7, MB);
    mem[3] = mk(2'd3, 2'd3, 12'd7, MG);
    mem[4] = mk(2'd3, 2'd2, 12'd7, MB);
    mem[6] = mk(2'd3, 2'd3, 12'd7, MB);
    mem[8] = mk(2'd1, 2'd1, 12'd7, MB);
    run("R6", 1'b0, 1'b1, MA, 12'd7, 1'b0);
    check("R6", "evict 6", {60'd0, result_idx}, 64'd6);

    // R7: nothing qualifies
    fill_persist();
    run("R7", 1'b0, 1'b1, MA, 12'd7, 1'b0);
    check("R7", "not_found", {63'd0, not_found}, 64'd0); // sampled one cycle after the pulse

    // R8: requests while busy are ignored
    fill_persist();
    mem[5] = mk(2'd0, 2'd1, 12'd4, MA);
    run("R8", 1'b0, 1'b1, MA, 12'd4, 1'b1);
    check("R8", "first request kept", {60'd0, result_idx}, 64'd5);

    // R5 sweep: random tables, small field alphabet so every tier occurs
    for (int t = 0; t < 300; t++) begin
      for (int i = 0; i < N; i++) begin
        logic [1:0] ty = (t % 3 == 0) ? 2'(1 + $urandom % 3) : 2'($urandom % 4);
        if (t % 3 == 1 && ty == 2'd0) ty = 2'd1;
        mem[i] = mk(2'($urandom % 4), ty, ($urandom % 2) ? 12'd5 : 12'd0, pick_mac(int'($urandom)));
      end
      run("R5", 1'($urandom % 2), 1'($urandom % 2), pick_mac(int'($urandom)),
          ($urandom % 2) ? 12'd5 : 12'd0, (t % 10) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule